// File: doc/BRIEF.md
# DTMF Zero-Crossing Tone Classifier

This block sits after a pair of external band-split comparators in a touch-tone receiver. Each comparator delivers a one-bit square wave: one carries the low (row) group of tones, the other the high (column) group. For each wave the block counts system-clock cycles between rising edges. It checks every measured period against the windows for the four tones of that group. When both groups hold a steady, valid tone, it raises an early signal-condition flag and reports which row and which column were heard.

A tone counts as present only when the last four periods measured in a group all fall inside the same tone window. A single odd period, such as a burst that speech can produce, therefore breaks the condition at once. A group that shows no rising edge for about 2.5 ms has its history discarded. The next edge after such a gap only restarts timing. The flag and indices feed a separate steering controller, which applies the tone-duration and pause guard times.

Each window is symmetric in frequency around its nominal tone, with a half-width set in per-mille (default 25, i.e. ±2.5 %). That width lies above the required accept tolerance and below the required reject deviation for every one of the eight tones. The clock frequency is a parameter (default 3,579,545 Hz), and all period bounds are derived from it at elaboration.

Top module: `dtmf_zc_classifier`

## Requirements
- R1: While the synchronous active-low reset is asserted and on the first cycle after it, `est` is 0 and `row_idx` and `col_idx` are both 0. All history and counters are cleared.
- R2: A low-group tone of 697, 770, 852 or 941 Hz is reported as row index 0, 1, 2 or 3 respectively.
- R3: A high-group tone of 1209, 1336, 1477 or 1633 Hz is reported as column index 0, 1, 2 or 3 respectively.
- R4: A tone that differs from its nominal frequency by up to 1.5 % plus 2 Hz, in either direction, is still classified as that tone.
- R5: A tone that differs from its nominal frequency by 3.5 % or more is classified as no tone, and `est` stays 0.
- R6: `est` is 1 only while both groups hold a valid tone. Whenever `est` is 0, `row_idx` and `col_idx` read 0.
- R7: A group is valid only when its four most recent measured periods all lie in the window of one and the same tone. After a change of frequency, the group stays invalid until four periods of the new tone have been measured.
- R8: If a group sees no rising edge for TIMEOUT cycles (2.5 ms of clock), its history is cleared and it turns invalid. The first edge after that only restarts the count and yields no period. Before the timeout, a silent group keeps its last state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at CLK_HZ |
| rst_n | input | 1 | Synchronous reset, active low |
| low_sq | input | 1 | Squared low-group signal (asynchronous) |
| high_sq | input | 1 | Squared high-group signal (asynchronous) |
| est | output | 1 | Early signal condition: both groups valid |
| row_idx | output | 2 | Low-group tone index, 0 when `est` is 0 |
| col_idx | output | 2 | High-group tone index, 0 when `est` is 0 |

## Verification
On every cycle, the assertions check the following. No two tone windows of a group ever match the same period. A measured period is never zero. No period is produced on the cycle after a timeout. A group's tone index holds still while it stays valid and no new sample arrives. A timeout in either group pulls `est` low two cycles later. Only the bench's scenarios can show the rest: that real square waves at each nominal frequency map to the right row and column; that the 1.5 % + 2 Hz deviations are accepted and the 3.5 % ones rejected; that a frequency change drops the flag until four fresh periods agree; and that a silent group survives a gap shorter than the timeout but not a longer one.

// File: rtl/dtmf_zc_pkg.sv
package dtmf_zc_pkg;

  localparam int unsigned TONES_PER_GROUP = 4;

  // nominal tone frequency in Hz; hi_grp selects the column group
  function automatic int unsigned tone_hz(input bit hi_grp, input int unsigned idx);
    int unsigned f;
    if (hi_grp) begin
      case (idx)
        0: f = 1209;
        1: f = 1336;
        2: f = 1477;
        default: f = 1633;
      endcase
    end else begin
      case (idx)
        0: f = 697;
        1: f = 770;
        2: f = 852;
        default: f = 941;
      endcase
    end
    return f;
  endfunction

  // shortest accepted period (tone at nominal * (1 + permil/1000))
  function automatic int unsigned period_lo(input longint unsigned clk_hz,
                                            input int unsigned hz,
                                            input int unsigned permil);
    longint unsigned num;
    longint unsigned den;
    num = clk_hz * 64'd1000;
    den = longint'(hz) * longint'(1000 + permil);
    return int'((num + den - 1) / den);
  endfunction

  // longest accepted period (tone at nominal * (1 - permil/1000))
  function automatic int unsigned period_hi(input longint unsigned clk_hz,
                                            input int unsigned hz,
                                            input int unsigned permil);
    longint unsigned num;
    longint unsigned den;
    num = clk_hz * 64'd1000;
    den = longint'(hz) * longint'(1000 - permil);
    return int'(num / den);
  endfunction

  // cycles of silence tolerated before a group is declared lost (2.5 ms)
  function automatic int unsigned silence_limit(input longint unsigned clk_hz);
    return int'((clk_hz * 64'd25) / 64'd10000);
  endfunction

endpackage

// File: rtl/dtmf_edge_sync.sv
module dtmf_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sq_in,
  output logic rise
);
  logic meta_q, sync_q, last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= sq_in;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign rise = sync_q & ~last_q;
endmodule

// File: rtl/dtmf_period_meter.sv
module dtmf_period_meter #(
  parameter int unsigned LIMIT = 8948,
  parameter int unsigned CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  output logic             sample_stb,
  output logic [CNT_W-1:0] sample_cnt,
  output logic             ovf_stb
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             at_limit;

  assign at_limit   = (cnt_q == LAST);
  assign sample_stb = rise & armed_q;
  assign sample_cnt = cnt_q + 1'b1;
  assign ovf_stb    = ~rise & at_limit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (rise) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (at_limit) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  // R8: after a timeout the next edge only re-arms, it never yields a period
  p_no_sample_after_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_stb |=> !sample_stb);

  // R8: a reported period is never empty
  p_sample_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (sample_cnt != '0));
endmodule

// File: rtl/dtmf_tone_window.sv
module dtmf_tone_window #(
  parameter bit          HI_GRP     = 1'b0,
  parameter int unsigned CLK_HZ     = 3579545,
  parameter int unsigned WIN_PERMIL = 25,
  parameter int unsigned CNT_W      = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period,
  input  logic             present,
  output logic             hit,
  output logic [1:0]       idx
);
  localparam int unsigned N = dtmf_zc_pkg::TONES_PER_GROUP;

  logic [N-1:0] match;

  for (genvar j = 0; j < N; j++) begin : g_win
    localparam int unsigned HZ = dtmf_zc_pkg::tone_hz(HI_GRP, j);
    localparam int unsigned LO = dtmf_zc_pkg::period_lo(CLK_HZ, HZ, WIN_PERMIL);
    localparam int unsigned HI = dtmf_zc_pkg::period_hi(CLK_HZ, HZ, WIN_PERMIL);
    assign match[j] = (32'(period) >= LO) && (32'(period) <= HI);
  end

  always_comb begin
    idx = 2'd0;
    for (int k = 0; k < N; k++) begin
      if (match[k]) idx = 2'(k);
    end
  end

  assign hit = present & (|match);

  // R2/R3: tone windows of a group never overlap
  p_one_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
endmodule

// File: rtl/dtmf_group_tracker.sv
module dtmf_group_tracker #(
  parameter bit          HI_GRP     = 1'b0,
  parameter int unsigned CLK_HZ     = 3579545,
  parameter int unsigned WIN_PERMIL = 25,
  parameter int unsigned HIST       = 4,
  parameter int unsigned CNT_W      = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_stb,
  input  logic [CNT_W-1:0] sample_cnt,
  input  logic             ovf_stb,
  output logic             grp_valid,
  output logic [1:0]       grp_idx
);
  logic [CNT_W-1:0] slot_cnt [HIST];
  logic [HIST-1:0]  slot_ok;
  logic [HIST-1:0]  slot_hit;
  logic [1:0]       slot_idx [HIST];
  logic             agree;
  logic             valid_q;
  logic [1:0]       idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_ok <= '0;
      for (int i = 0; i < HIST; i++) slot_cnt[i] <= '0;
    end else if (ovf_stb) begin
      slot_ok <= '0;
    end else if (sample_stb) begin
      slot_cnt[0] <= sample_cnt;
      slot_ok     <= {slot_ok[HIST-2:0], 1'b1};
      for (int i = 1; i < HIST; i++) slot_cnt[i] <= slot_cnt[i-1];
    end
  end

  for (genvar s = 0; s < HIST; s++) begin : g_slot
    dtmf_tone_window #(
      .HI_GRP(HI_GRP), .CLK_HZ(CLK_HZ), .WIN_PERMIL(WIN_PERMIL), .CNT_W(CNT_W)
    ) u_win (
      .clk    (clk),
      .rst_n  (rst_n),
      .period (slot_cnt[s]),
      .present(slot_ok[s]),
      .hit    (slot_hit[s]),
      .idx    (slot_idx[s])
    );
  end

  always_comb begin
    agree = &slot_hit;
    for (int i = 1; i < HIST; i++) begin
      if (slot_idx[i] != slot_idx[0]) agree = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      idx_q   <= 2'd0;
    end else begin
      valid_q <= agree;
      idx_q   <= agree ? slot_idx[0] : 2'd0;
    end
  end

  assign grp_valid = valid_q;
  assign grp_idx   = idx_q;

  // R7: while valid and without a fresh sample the reported tone cannot move
  p_idx_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid && $past(grp_valid) && !$past(sample_stb, 2)) |-> $stable(grp_idx));

  // R8: a timeout clears the group two cycles later
  p_ovf_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_stb |=> ##1 !grp_valid);
endmodule

// File: rtl/dtmf_zc_classifier.sv
module dtmf_zc_classifier #(
  parameter int unsigned CLK_HZ     = 3579545,
  parameter int unsigned WIN_PERMIL = 25,
  parameter int unsigned HIST       = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       low_sq,
  input  logic       high_sq,
  output logic       est,
  output logic [1:0] row_idx,
  output logic [1:0] col_idx
);
  localparam int unsigned LIMIT = dtmf_zc_pkg::silence_limit(CLK_HZ);
  localparam int unsigned CNT_W = $clog2(LIMIT + 1);

  logic [1:0]       sq_in;
  logic [1:0]       rise_w;
  logic [1:0]       sample_w;
  logic [1:0]       ovf_w;
  logic [1:0]       valid_w;
  logic [CNT_W-1:0] period_w [2];
  logic [1:0]       idx_w    [2];

  assign sq_in = {high_sq, low_sq};

  for (genvar g = 0; g < 2; g++) begin : g_grp
    dtmf_edge_sync u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .sq_in(sq_in[g]),
      .rise (rise_w[g])
    );

    dtmf_period_meter #(.LIMIT(LIMIT), .CNT_W(CNT_W)) u_meter (
      .clk       (clk),
      .rst_n     (rst_n),
      .rise      (rise_w[g]),
      .sample_stb(sample_w[g]),
      .sample_cnt(period_w[g]),
      .ovf_stb   (ovf_w[g])
    );

    dtmf_group_tracker #(
      .HI_GRP(g == 1), .CLK_HZ(CLK_HZ), .WIN_PERMIL(WIN_PERMIL),
      .HIST(HIST), .CNT_W(CNT_W)
    ) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .sample_stb(sample_w[g]),
      .sample_cnt(period_w[g]),
      .ovf_stb   (ovf_w[g]),
      .grp_valid (valid_w[g]),
      .grp_idx   (idx_w[g])
    );
  end

  assign est     = &valid_w;
  assign row_idx = est ? idx_w[0] : 2'd0;
  assign col_idx = est ? idx_w[1] : 2'd0;

  // R6: losing the low group drops the condition flag
  p_est_drop_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_w[0] |=> ##1 !est);

  // R6: losing the high group drops the condition flag
  p_est_drop_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_w[1] |=> ##1 !est);
endmodule

// File: tb/dtmf_zc_classifier_bench.sv
module dtmf_zc_classifier_bench;
  localparam int unsigned CLK_HZ = 1000000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       low_sq = 1'b0;
  logic       high_sq = 1'b0;
  logic       est;
  logic [1:0] row_idx, col_idx;

  real f_low = 0.0, f_high = 0.0;
  real ph_low = 0.0, ph_high = 0.0;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    bit       est;
    bit [1:0] row;
    bit [1:0] col;
    string    tag;
  } exp_t;

  exp_t exp_q[$];
  event chk_ev;

  always #4 clk = ~clk;

  dtmf_zc_classifier #(.CLK_HZ(CLK_HZ)) u_dtmf_zc_classifier (
    .clk(clk), .rst_n(rst_n), .low_sq(low_sq), .high_sq(high_sq),
    .est(est), .row_idx(row_idx), .col_idx(col_idx)
  );

  // square-wave generators, updated away from the sampling edge
  always @(negedge clk) begin
    if (f_low > 0.0) begin
      ph_low = ph_low + f_low / CLK_HZ;
      if (ph_low >= 1.0) ph_low = ph_low - 1.0;
      low_sq <= (ph_low < 0.5);
    end else low_sq <= 1'b0;
    if (f_high > 0.0) begin
      ph_high = ph_high + f_high / CLK_HZ;
      if (ph_high >= 1.0) ph_high = ph_high - 1.0;
      high_sq <= (ph_high < 0.5);
    end else high_sq <= 1'b0;
  end

  // monitor: pop expected item and compare with outputs
  always @(chk_ev) begin
    exp_t e;
    while (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      n_checks++;
      if (est !== e.est || row_idx !== e.row || col_idx !== e.col) begin
        n_fail++;
        $display("FAIL %s: est/row/col actual %0b/%0d/%0d expected %0b/%0d/%0d",
                 e.tag, est, row_idx, col_idx, e.est, e.row, e.col);
      end
    end
  end

  task automatic expect_out(input bit e, input bit [1:0] r, input bit [1:0] c,
                            input string tag);
    exp_t it;
    it.est = e; it.row = r; it.col = c; it.tag = tag;
    exp_q.push_back(it);
    -> chk_ev;
    #1;
  endtask

  task automatic play(input real fl, input real fh, input int cycles);
    f_low = fl;
    f_high = fh;
    repeat (cycles) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_out(0, 0, 0, "R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    expect_out(0, 0, 0, "R1 after reset");

    play(697, 1209, 8000);  expect_out(1, 0, 0, "R2 R3 697+1209");
    play(770, 1336, 3000);  expect_out(0, 0, 0, "R7 mixed history after change");
    play(770, 1336, 6000);  expect_out(1, 1, 1, "R7 R2 R3 770+1336 settled");
    play(852, 1477, 8000);  expect_out(1, 2, 2, "R2 R3 852+1477");
    play(941, 1633, 8000);  expect_out(1, 3, 3, "R2 R3 941+1633");
    play(697, 1633, 8000);  expect_out(1, 0, 3, "R2 R3 697+1633");
    play(941, 1209, 8000);  expect_out(1, 3, 0, "R2 R3 941+1209");

    play(697.0 * 1.015 + 2.0, 1336, 8000);
    expect_out(1, 0, 1, "R4 low +1.5%+2Hz");
    play(941.0 * 0.985 - 2.0, 1633.0 * 0.985 - 2.0, 8000);
    expect_out(1, 3, 3, "R4 both -1.5%-2Hz");
    play(852, 1209.0 * 1.015 + 2.0, 8000);
    expect_out(1, 2, 0, "R4 high +1.5%+2Hz");

    play(697.0 * 1.035, 1209, 8000);
    expect_out(0, 0, 0, "R5 R6 low +3.5% rejected");
    play(697, 1633.0 * 0.965, 8000);
    expect_out(0, 0, 0, "R5 R6 high -3.5% rejected");

    play(770, 1209, 8000);  expect_out(1, 1, 0, "R2 R3 770+1209");
    play(0, 1209, 1000);    expect_out(1, 1, 0, "R8 short silence held");
    play(0, 1209, 2000);    expect_out(0, 0, 0, "R8 R6 timeout drops low group");
    play(770, 1209, 8000);  expect_out(1, 1, 0, "R8 rearm after timeout");

    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    expect_out(0, 0, 0, "R1 reset mid-tone");
    rst_n = 1'b1;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule